// File: doc/BRIEF.md
# Serial Equalizer Command Transmitter

This block sits on the host side of a three-wire control port for a graphic equalizer. It turns a single start request into one or two 8-bit serial command words. It drives a serial data line, a generated serial clock and a strobe line. A full update carries a band-select word and then a gain word. A gain-only update skips the band word and sends only the gain word, which changes the gain of the band the receiver already has selected.

Each word goes out least significant bit first. The data line changes only on the falling serial clock edge, so the receiver can sample it on the rising edge. When a word is complete, the serial clock is parked low. After a programmable delay the block issues one strobe pulse. Every interval is a whole number of system clock cycles, set by parameters. Elaboration stops if any of these parameters gives less than one microsecond of setup, hold, clock-to-strobe or strobe width, or a serial clock faster than 500 kHz.

Top module: `eqtx_serial_tx`

## Requirements
- R1: Each word is 8 bits and is sent bit 0 first. Bit i is on `eq_data` while the i-th `eq_clk` pulse is high, and a word is followed by exactly one strobe.
- R2: `eq_data` changes only while `eq_clk` is low. Each bit is stable for HALF_DIV cycles before its rising clock edge and for HALF_DIV cycles after it.
- R3: Each high half and each low half of the serial clock lasts exactly HALF_DIV system cycles. HALF_DIV must be at least CLK_MHZ, which keeps the serial clock at or below 500 kHz.
- R4: After the last bit, `eq_clk` stays low and `eq_data` returns low. The strobe becomes active STB_DELAY cycles after the final falling edge, which is HALF_DIV+STB_DELAY cycles after the final rising edge.
- R5: The strobe stays active for exactly STB_WIDTH cycles, and `eq_clk` is never high while it is active. With STB_ACTIVE_LOW=1 the active level is 0; otherwise it is 1.
- R6: When `send_band`=1 at start, `band_word` is sent first and the gain word second. Each word gets its own strobe, and RECOV_CYC idle cycles separate the first strobe from the next word.
- R7: When `send_band`=0 at start, only `gain_word` is sent, followed by one strobe.
- R8: `start` is accepted only while `busy`=0. The first clock low phase begins in the cycle after acceptance, and `busy` stays 1 from that cycle through the done cycle. A `start` seen while `busy`=1 has no effect.
- R9: `done` is high for exactly one cycle, directly after the last strobe ends and with `busy` still high. `busy` falls in the cycle after.
- R10: After reset and whenever idle: `eq_clk`=0, `eq_data`=0, the strobe is at its inactive level, and `busy`=`done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| send_band | input | 1 | 1: send band word then gain word; 0: gain word only |
| band_word | input | WORD_W | Band-select command word |
| gain_word | input | WORD_W | Gain command word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| eq_clk | output | 1 | Generated serial clock |
| eq_data | output | 1 | Serial data, LSB first |
| eq_strobe | output | 1 | Word latch strobe |

## Verification
The collision of interest is a new start request meeting the end of a transfer. A request can be raised while a word is shifting, and it can be held across the done cycle, so that it lands in the cycle where the last strobe releases or in the first idle cycle after it. Both cases are provoked: a stray start pulse mid-transfer with different words on the inputs, and a start held high through several transfers. A per-cycle behavioural model, which accepts a request only when its own expected state is idle, judges each case. The words recovered from the serial lines must match only the accepted requests, in order.

// File: rtl/eqtx_pkg.sv
package eqtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_STB,
        ST_RECOV,
        ST_DONE
    } eqtx_state_e;

    typedef enum logic [1:0] {
        SRC_BAND_IN,
        SRC_GAIN_IN,
        SRC_GAIN_Q
    } eqtx_src_e;

    typedef struct packed {
        logic clk_hi;
        logic data_en;
        logic stb_on;
    } eqtx_line_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/eqtx_timer.sv
module eqtx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/eqtx_shreg.sv
module eqtx_shreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    output logic              bit_out,
    output logic              last_bit
);
    localparam int IDX_W = (WORD_W < 2) ? 1 : $clog2(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (idx_q == IDX_W'(WORD_W - 1));
endmodule

// File: rtl/eqtx_ctrl.sv
module eqtx_ctrl
    import eqtx_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int HALF_DIV  = 125,
    parameter int STB_DELAY = 100,
    parameter int STB_WIDTH = 120,
    parameter int RECOV_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             send_band,
    input  logic             tmr_exp,
    input  logic             bit_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_shift,
    output eqtx_src_e        sh_src,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output eqtx_line_t       line
);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] DELAY_LD = CNT_W'(STB_DELAY - 1);
    localparam logic [CNT_W-1:0] WIDTH_LD = CNT_W'(STB_WIDTH - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    eqtx_state_e st_q, st_d;
    logic        pend_q;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_src   = SRC_BAND_IN;
        case (st_q)
            ST_IDLE: if (start) begin
                st_d     = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
                sh_load  = 1'b1;
                sh_src   = send_band ? SRC_BAND_IN : SRC_GAIN_IN;
            end
            ST_LOW: if (tmr_exp) begin
                st_d     = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
            end
            ST_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (bit_last) begin
                    st_d    = ST_GAP;
                    tmr_val = DELAY_LD;
                end else begin
                    st_d     = ST_LOW;
                    tmr_val  = HALF_LD;
                    sh_shift = 1'b1;
                end
            end
            ST_GAP: if (tmr_exp) begin
                st_d     = ST_STB;
                tmr_load = 1'b1;
                tmr_val  = WIDTH_LD;
            end
            ST_STB: if (tmr_exp) begin
                if (pend_q) begin
                    st_d     = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = RECOV_LD;
                end else begin
                    st_d = ST_DONE;
                end
            end
            ST_RECOV: if (tmr_exp) begin
                st_d     = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
                sh_load  = 1'b1;
                sh_src   = SRC_GAIN_Q;
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start)
                pend_q <= send_band;
            else if (st_q == ST_RECOV && tmr_exp)
                pend_q <= 1'b0;
        end
    end

    assign accept       = (st_q == ST_IDLE) && start;
    assign busy         = (st_q != ST_IDLE);
    assign done         = (st_q == ST_DONE);
    assign line.clk_hi  = (st_q == ST_HIGH);
    assign line.data_en = (st_q == ST_LOW) || (st_q == ST_HIGH);
    assign line.stb_on  = (st_q == ST_STB);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

    // R6
    second_word_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RECOV) |-> pend_q);
endmodule

// File: rtl/eqtx_serial_tx.sv
module eqtx_serial_tx
    import eqtx_pkg::*;
#(
    parameter int CLK_MHZ        = 100,
    parameter int WORD_W         = 8,
    parameter int HALF_DIV       = 125,
    parameter int STB_DELAY      = 100,
    parameter int STB_WIDTH      = 120,
    parameter int RECOV_CYC      = 100,
    parameter bit STB_ACTIVE_LOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              send_band,
    input  logic [WORD_W-1:0] band_word,
    input  logic [WORD_W-1:0] gain_word,
    output logic              busy,
    output logic              done,
    output logic              eq_clk,
    output logic              eq_data,
    output logic              eq_strobe
);
    localparam int unsigned MAX_LEN = max_of(max_of(HALF_DIV, STB_DELAY), max_of(STB_WIDTH, RECOV_CYC));
    localparam int CNT_W = cnt_bits(MAX_LEN);

    if (HALF_DIV < CLK_MHZ) begin : g_half_too_short
        $error("HALF_DIV gives less than 1 us per clock half");
    end
    if (STB_WIDTH < CLK_MHZ) begin : g_stb_too_short
        $error("STB_WIDTH gives less than 1 us strobe");
    end
    if (STB_DELAY < 1 || RECOV_CYC < 1) begin : g_zero_len
        $error("STB_DELAY and RECOV_CYC must be at least 1");
    end

    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_bit, sh_last, accept;
    eqtx_src_e        sh_src;
    eqtx_line_t       line;
    logic [WORD_W-1:0] gain_q, load_word;

    always_ff @(posedge clk) begin
        if (rst)
            gain_q <= '0;
        else if (accept)
            gain_q <= gain_word;
    end

    always_comb begin
        case (sh_src)
            SRC_BAND_IN: load_word = band_word;
            SRC_GAIN_IN: load_word = gain_word;
            default:     load_word = gain_q;
        endcase
    end

    eqtx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    eqtx_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk(clk), .rst(rst), .load(sh_load), .load_val(load_word), .shift(sh_shift),
        .bit_out(sh_bit), .last_bit(sh_last)
    );

    eqtx_ctrl #(
        .CNT_W(CNT_W), .HALF_DIV(HALF_DIV), .STB_DELAY(STB_DELAY),
        .STB_WIDTH(STB_WIDTH), .RECOV_CYC(RECOV_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .send_band(send_band),
        .tmr_exp(tmr_exp), .bit_last(sh_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .sh_load(sh_load), .sh_shift(sh_shift), .sh_src(sh_src), .accept(accept),
        .busy(busy), .done(done), .line(line)
    );

    assign eq_clk  = line.clk_hi;
    assign eq_data = line.data_en & sh_bit;

    if (STB_ACTIVE_LOW) begin : g_stb_low
        assign eq_strobe = ~line.stb_on;
    end else begin : g_stb_high
        assign eq_strobe = line.stb_on;
    end

    logic stb_act;
    assign stb_act = (eq_strobe != STB_ACTIVE_LOW);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eq_clk && $past(eq_clk)) |-> $stable(eq_data));

    // R5
    stb_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        stb_act |-> (!eq_clk && !eq_data));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!eq_clk && !eq_data && !stb_act && !done));
endmodule

// File: tb/sim_eqtx_serial_tx.sv
`timescale 1ns/1ps
module sim_eqtx_serial_tx;
    localparam int CLK_MHZ = 100;
    localparam int H  = 125;
    localparam int D  = 100;
    localparam int W  = 120;
    localparam int RC = 100;
    localparam bit ACT_LOW = 1'b1;
    localparam int MINC = CLK_MHZ;

    logic clk = 0, rst = 1, start = 0, send_band = 0;
    logic [7:0] band_word = 0, gain_word = 0;
    logic busy, done, eq_clk, eq_data, eq_strobe;

    always #5 clk = ~clk;

    eqtx_serial_tx #(
        .CLK_MHZ(CLK_MHZ), .WORD_W(8), .HALF_DIV(H), .STB_DELAY(D),
        .STB_WIDTH(W), .RECOV_CYC(RC), .STB_ACTIVE_LOW(ACT_LOW)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .send_band(send_band),
        .band_word(band_word), .gain_word(gain_word), .busy(busy), .done(done),
        .eq_clk(eq_clk), .eq_data(eq_data), .eq_strobe(eq_strobe)
    );

    int errors = 0, checks = 0;
    logic [4:0] model_q[$];   // {clk, data, stb_active, busy, done}
    logic [7:0] exp_words[$];
    int accepted = 0, done_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_word(input logic [7:0] w, input bit last);
        for (int i = 0; i < 8; i++) begin
            repeat (H) model_q.push_back({1'b0, w[i], 1'b0, 1'b1, 1'b0});
            repeat (H) model_q.push_back({1'b1, w[i], 1'b0, 1'b1, 1'b0});
        end
        repeat (D) model_q.push_back(5'b00010);
        repeat (W) model_q.push_back(5'b00110);
        if (last) model_q.push_back(5'b00011);
        else repeat (RC) model_q.push_back(5'b00010);
        exp_words.push_back(w);
    endtask

    // Cycle model and line deserializer, sampled at the falling edge
    int cyc = 0, last_chg = 0, last_rise = 0, last_fall = 0, stb_t0 = 0, nbits = 0;
    logic prev_clk = 0, prev_data = 0, prev_stb = 0;
    logic [7:0] cap = 0;

    always @(negedge clk) begin
        logic [4:0] e;
        logic stb_act;
        bit was_empty;
        cyc++;
        stb_act = (eq_strobe == ~ACT_LOW);
        if (!rst) begin
            was_empty = (model_q.size() == 0);
            e = was_empty ? 5'b00000 : model_q.pop_front();
            chk(eq_clk == e[4], "R3 eq_clk", eq_clk, e[4]);
            chk(eq_data == e[3], "R1 eq_data", eq_data, e[3]);
            chk(stb_act == e[2], "R5 strobe", stb_act, e[2]);
            chk(busy == e[1], "R8 busy", busy, e[1]);
            chk(done == e[0], "R9 done", done, e[0]);
            if (done) done_seen++;
            if (was_empty && start) begin
                accepted++;
                if (send_band) begin
                    push_word(band_word, 1'b0);
                    push_word(gain_word, 1'b1);
                end else begin
                    push_word(gain_word, 1'b1);
                end
            end
            if (eq_data != prev_data) begin
                if (eq_clk && prev_clk) chk(0, "R2 hold", 1, 0);
                last_chg = cyc;
            end
            if (eq_clk && !prev_clk) begin
                chk(cyc - last_chg >= MINC, "R2 setup", cyc - last_chg, MINC);
                if (last_fall > 0) chk(cyc - last_fall >= H, "R3 low half", cyc - last_fall, H);
                last_rise = cyc;
                cap = {eq_data, cap[7:1]};
                nbits++;
            end
            if (!eq_clk && prev_clk) begin
                chk(cyc - last_rise == H, "R3 high half", cyc - last_rise, H);
                last_fall = cyc;
            end
            if (stb_act && !prev_stb) begin
                chk(cyc - last_rise == H + D, "R4 clk to strobe", cyc - last_rise, H + D);
                chk(nbits == 8, "R1 bit count", nbits, 8);
                if (exp_words.size() == 0) chk(0, "R6 unexpected word", cap, -1);
                else begin
                    logic [7:0] x;
                    x = exp_words.pop_front();
                    chk(cap == x, "R7 word", cap, x);
                end
                nbits = 0;
                stb_t0 = cyc;
            end
            if (!stb_act && prev_stb)
                chk(cyc - stb_t0 == W, "R5 strobe width", cyc - stb_t0, W);
        end
        prev_clk = eq_clk; prev_data = eq_data; prev_stb = stb_act;
    end

    task automatic go(input logic [7:0] b, input logic [7:0] g, input bit sb);
        @(posedge clk); #1;
        while (busy) begin @(posedge clk); #1; end
        band_word = b; gain_word = g; send_band = sb; start = 1;
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy) begin @(posedge clk); #1; end
        repeat (5) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        // R10 reset state
        chk(eq_clk == 0 && eq_data == 0, "R10 idle lines", {eq_clk, eq_data}, 0);
        chk(eq_strobe == ACT_LOW, "R10 strobe idle", eq_strobe, ACT_LOW);
        chk(busy == 0 && done == 0, "R10 busy/done", {busy, done}, 0);

        go(8'h5A, 8'hC3, 1'b1);       // R6 pair
        go(8'hEE, 8'h81, 1'b0);       // R7 gain only
        go(8'h00, 8'hFF, 1'b1);       // R1 extremes
        go(8'h3C, 8'hA5, 1'b1);       // R8 stray start mid-transfer
        repeat (700) @(posedge clk);
        #1 band_word = 8'h11; gain_word = 8'h22; send_band = 1; start = 1;
        @(posedge clk); #1 start = 0;
        wait_idle();
        // R8 start held across done: retriggers in first idle cycle
        band_word = 8'h99; gain_word = 8'h6E; send_band = 0; start = 1;
        while (done_seen < accepted || accepted < 7) begin @(posedge clk); #1; end
        repeat (300) @(posedge clk);
        #1 start = 0;
        wait_idle();
        repeat (20) @(posedge clk);
        @(negedge clk); #1;
        chk(exp_words.size() == 0, "R6 words pending", exp_words.size(), 0);
        chk(done_seen == accepted, "R9 done count", done_seen, accepted);
        chk(eq_strobe == ACT_LOW && !busy, "R10 final idle", {eq_strobe, busy}, {ACT_LOW, 1'b0});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule